// File: doc/BRIEF.md
# Polled Serial Receiver with Byte Queue

This block takes an asynchronous serial line and turns it into bytes for a processor that polls. The line first passes through a capture register, and a frame decoder then times each bit with a counter whose period, in clock cycles, is a parameter. With a 96 MHz clock and a 31250 baud line, for example, that period is 3072 cycles. Every byte that decodes correctly goes into a four-entry queue.

The processor sees the block as a single read-only word. Each strobe on the read select removes the oldest byte from the queue. On the following cycle the block returns that byte together with two flags: one says the byte field is real, and one says a byte was lost because the queue was full. Software polls the word in a loop. It acts on the byte when the valid flag is set and reports a loss when the loss flag is set.

Top module: `serial_rx_fifo_reg`

## Requirements
- R1: The line capture register resets to logic 1, so a line that stays high after reset delivers no byte and a read returns the empty word 0x0000_0000.
- R2: A frame begins on a high-to-low transition of the captured line and is confirmed only if the line is still low half a bit period later; a shorter low pulse is ignored. Eight data bits follow, least significant bit first, each sampled in the middle of its BIT_CYCLES-long period.
- R3: A frame whose stop bit samples low is discarded and never reaches the queue.
- R4: The queue holds DEPTH (default 4) bytes and returns them in arrival order.
- R5: The read word carries the loss flag in bit 31, the valid flag in bit 30, zeros in bits 29:8 and the byte in bits 7:0. It appears on rd_data one clock after the cycle in which rd_sel is high and is held until the next read.
- R6: A read while the queue is empty returns bit 30 clear and bits 7:0 zero, and leaves the queue contents and pointers unchanged.
- R7: A byte that completes while the queue is full, with no read in the same cycle, is dropped and sets the loss flag. The first read after that returns bit 31 set and clears the flag, so later reads return it clear.
- R8: If a byte is stored and a read removes an entry in the same cycle while the queue is not empty, both take effect and the occupancy does not change.
- R9: While reset is asserted, rd_data is 0x0000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serial_in | input | 1 | Asynchronous serial receive line, idle high |
| rd_sel | input | 1 | Read strobe for the register; pops one entry |
| rd_data | output | 32 | Flags and byte of the last read |

## Verification
A wrong bit counter or a wrong mid-bit sample point shows up as a corrupted or bit-reversed byte in bits 7:0 on the read that follows the frame, about ten bit periods after the start edge. A queue pointer or occupancy error shows up as reordered, repeated or missing bytes over a run of reads, or as bit 30 set on a read that should be empty. A loss flag that is not sticky, or that is never cleared, shows up as bit 31 wrong on the first or the second read after a byte is dropped. The bench therefore checks every read word in full against a queue of expected words. It sweeps the timing of one read across the cycle in which a byte is stored, to reach the case where a store and a removal happen together.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 32;
endpackage

// File: rtl/srx_line_sync.sv
module srx_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_q
);
  // Idle level is high, so reset to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b1;
    else        line_q <= line_in;
  end
endmodule

// File: rtl/srx_deserializer.sv
module srx_deserializer import srx_pkg::*; #(
  parameter int BIT_CYCLES = 3072
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_q,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_out
);
  localparam int CNT_W = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(BIT_CYCLES / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(BIT_CYCLES - 1);

  rx_state_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [2:0]        idx_q, idx_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              prev_q;
  logic              vld_d;
  logic              fall;

  assign fall = prev_q & ~line_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    vld_d = 1'b0;
    unique case (st_q)
      RX_IDLE: begin
        if (fall) begin
          st_d  = RX_START;
          cnt_d = '0;
        end
      end
      RX_START: begin
        if (cnt_q == HALF_LAST) begin
          cnt_d = '0;
          idx_d = '0;
          st_d  = line_q ? RX_IDLE : RX_DATA;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RX_DATA: begin
        if (cnt_q == FULL_LAST) begin
          cnt_d = '0;
          sh_d  = {line_q, sh_q[BYTE_W-1:1]};
          if (idx_q == 3'd7) st_d = RX_STOP;
          else               idx_d = idx_q + 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RX_STOP: begin
        if (cnt_q == FULL_LAST) begin
          cnt_d = '0;
          vld_d = line_q;
          st_d  = RX_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= RX_IDLE;
      cnt_q    <= '0;
      idx_q    <= '0;
      sh_q     <= '0;
      prev_q   <= 1'b1;
      byte_vld <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      idx_q    <= idx_d;
      sh_q     <= sh_d;
      prev_q   <= line_q;
      byte_vld <= vld_d;
    end
  end

  assign byte_out = sh_q;
endmodule

// File: rtl/srx_byte_fifo.sv
module srx_byte_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [WIDTH-1:0]           din,
  input  logic                       pop,
  output logic [WIDTH-1:0]           dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop & ~empty;
  assign do_push = push & (~full | do_pop);

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             mem[g] <= '0;
      else if (do_push && wp_q == AW'(g))     mem[g] <= din;
    end
  end

  assign dout  = mem[rp_q];
  assign count = cnt_q;
endmodule

// File: rtl/serial_rx_fifo_reg.sv
module serial_rx_fifo_reg import srx_pkg::*; #(
  parameter int BIT_CYCLES = 3072,
  parameter int DEPTH      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serial_in,
  input  logic              rd_sel,
  output logic [WORD_W-1:0] rd_data
);
  localparam int CW = $clog2(DEPTH + 1);

  logic              line_q;
  logic              byte_vld;
  logic [BYTE_W-1:0] byte_out;
  logic [BYTE_W-1:0] head;
  logic [CW-1:0]     fifo_count;
  logic              fifo_full, fifo_empty;
  logic              ovf_q, ovf_d, drop;
  logic [WORD_W-1:0] word_d;

  srx_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(serial_in), .line_q(line_q)
  );

  srx_deserializer #(.BIT_CYCLES(BIT_CYCLES)) u_deser (
    .clk(clk), .rst_n(rst_n), .line_q(line_q),
    .byte_vld(byte_vld), .byte_out(byte_out)
  );

  srx_byte_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(byte_vld), .din(byte_out),
    .pop(rd_sel), .dout(head), .count(fifo_count),
    .full(fifo_full), .empty(fifo_empty)
  );

  assign drop = byte_vld & fifo_full & ~rd_sel;

  always_comb begin
    ovf_d = ovf_q;
    if (rd_sel) ovf_d = 1'b0;
    if (drop)   ovf_d = 1'b1;
    word_d = {ovf_q, ~fifo_empty, {(WORD_W-BYTE_W-2){1'b0}},
              fifo_empty ? {BYTE_W{1'b0}} : head};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q   <= 1'b0;
      rd_data <= '0;
    end else begin
      ovf_q <= ovf_d;
      if (rd_sel) rd_data <= word_d;
    end
  end
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_sel,
  input logic [31:0]   rd_data,
  input logic [CW-1:0] count,
  input logic          push,
  input logic          ovf
);
  // R4
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R5
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel |=> $stable(rd_data));
  // R5
  valid_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel |=> rd_data[30] == ($past(count) != '0));
  // R6
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel && count == '0 && !push) |=> (count == '0 && rd_data[7:0] == 8'h00));
  // R7
  loss_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && count == CW'(DEPTH) && !rd_sel) |=> ovf);
  // R7
  loss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel && !(push && count == CW'(DEPTH))) |=> !ovf);
  // R8
  push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel && push && count != '0) |=> $stable(count));
endmodule

bind serial_rx_fifo_reg srx_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .rd_data(rd_data),
  .count(fifo_count), .push(byte_vld), .ovf(ovf_q)
);

// File: tb/serial_rx_fifo_reg_test.sv
module serial_rx_fifo_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam int BITC       = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        serial_in;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;

  int          checks = 0;
  int          fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        pend = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_rx_fifo_reg #(.BIT_CYCLES(BITC), .DEPTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .serial_in(serial_in),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  function automatic logic [31:0] w(input logic o, input logic v, input logic [7:0] b);
    return {o, v, 22'b0, b};
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  // Monitor: compares each read word one cycle after its strobe
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) chk("scoreboard", rd_data, 32'hxxxx_xxxx);
      else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
    pend = rd_sel;
  end

  task automatic rd(input logic [31:0] e, input string r);
    exp_q.push_back(e);
    tag_q.push_back(r);
    @(posedge clk); #1 rd_sel = 1'b1;
    @(posedge clk); #1 rd_sel = 1'b0;
    @(negedge clk); #1;
  endtask

  task automatic level(input logic v);
    #1 serial_in = v;
    repeat (BITC) @(posedge clk);
  endtask

  task automatic tx(input logic [7:0] b, input logic stop);
    @(posedge clk);
    level(1'b0);
    for (int i = 0; i < 8; i++) level(b[i]);
    level(stop);
    level(1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    serial_in = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset word", rd_data, 32'h0);
    #1 rst_n = 1'b1;
    repeat (4 * BITC) @(posedge clk);
    rd(32'h0, "R1 idle line gives no byte");
    rd(32'h0, "R6 empty read");

    // R2 single byte, LSB first
    tx(8'h12, 1'b1);
    rd(w(0, 1, 8'h12), "R2 byte 0x12");
    rd(w(0, 0, 8'h00), "R6 empty after pop");
    tx(8'h80, 1'b1);
    rd(w(0, 1, 8'h80), "R2 msb only");

    // R2 short glitch ignored
    @(posedge clk); #1 serial_in = 1'b0;
    repeat (2) @(posedge clk); #1 serial_in = 1'b1;
    repeat (3 * BITC) @(posedge clk);
    rd(w(0, 0, 8'h00), "R2 glitch ignored");

    // R3 bad stop bit
    tx(8'h5C, 1'b0);
    repeat (2 * BITC) @(posedge clk);
    rd(w(0, 0, 8'h00), "R3 framing discard");

    // R4 order through a full queue
    tx(8'h34, 1'b1); tx(8'h56, 1'b1); tx(8'h78, 1'b1); tx(8'h9A, 1'b1);
    rd(w(0, 1, 8'h34), "R4 order 0");
    rd(w(0, 1, 8'h56), "R4 order 1");
    rd(w(0, 1, 8'h78), "R4 order 2");
    rd(w(0, 1, 8'h9A), "R4 order 3");
    rd(w(0, 0, 8'h00), "R6 drained");

    // R7 overflow drop, sticky until one read
    tx(8'h01, 1'b1); tx(8'h02, 1'b1); tx(8'h03, 1'b1); tx(8'h04, 1'b1);
    tx(8'hEE, 1'b1);
    rd(w(1, 1, 8'h01), "R7 loss reported");
    rd(w(0, 1, 8'h02), "R7 loss cleared");
    rd(w(0, 1, 8'h03), "R7 queue kept");
    rd(w(0, 1, 8'h04), "R7 queue kept");
    rd(w(0, 0, 8'h00), "R7 dropped byte absent");

    // R8 sweep a read across the cycle where the next byte is stored
    for (int k = 9 * BITC - 4; k <= 10 * BITC + 4; k++) begin
      tx(8'h4D, 1'b1);
      fork
        tx(8'hB2, 1'b1);
        begin
          repeat (k) @(posedge clk);
          rd(w(0, 1, 8'h4D), "R8 first");
        end
      join
      rd(w(0, 1, 8'hB2), "R8 second");
      rd(w(0, 0, 8'h00), "R8 empty");
    end

    repeat (4) @(posedge clk);
    if (exp_q.size() != 0) chk("scoreboard drain", 32'(exp_q.size()), 32'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule